// File: doc/BRIEF.md
# Token Position Counter and Address Encoder

This block keeps the positions of two circulating tokens, one moving along a ring of row servers and one along a ring of column servers. Each position is a count of `CNT_W` bits that wraps modulo 2^`CNT_W`. A server that passes a token on tells the block to step the matching count. The two counts never step in the same cycle, so a single ripple incrementer serves both of them. Its operand is steered from the count being stepped, and its result is written back to that same count.

When a column server holding both tokens has a pending event, it raises the send request. The block then presents the combined position as one address on a valid/ready output channel. The send request is acknowledged only after the receiver has taken the address.

All three request channels use a four-phase request/acknowledge handshake. Requesters keep at most one request high at a time. If that rule is broken, the block serves the row step first, then the column step, then the send.

Top module: `addr_token_counter`

## Requirements
- R1: After a synchronous active-high reset, both counts are zero, all three acknowledges are low and `addr_valid` is low.
- R2: A high `inc_row_req` seen while idle adds one to the row count and raises `inc_row_ack` on the next clock edge. The acknowledge stays high while the request stays high and falls on the edge after the request drops. The column count is unchanged.
- R3: A high `inc_col_req` seen while idle adds one to the column count, with the same acknowledge timing as R2. The row count is unchanged.
- R4: A count of 2^`CNT_W`-1 that is stepped becomes 0. The carry out of the top bit is discarded.
- R5: A high `send_req` seen while idle raises `addr_valid` on the next edge. `addr_data` then carries the column count in bits [2*CNT_W-1:CNT_W] and the row count in bits [CNT_W-1:0].
- R6: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high, `addr_data` holds its value and `send_ack` stays low. On the edge that samples `addr_ready` high, `addr_valid` falls and `send_ack` rises. `send_ack` falls on the edge after `send_req` drops.
- R7: A send leaves both counts unchanged, so repeated sends with no steps in between give the same address.
- R8: An acknowledge is high only on a cycle that follows a cycle in which its own request was high. With no request high, all acknowledges stay low. At most one request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_row_req | input | 1 | Request to step the row count |
| inc_row_ack | output | 1 | Acknowledge of the row step |
| inc_col_req | input | 1 | Request to step the column count |
| inc_col_ack | output | 1 | Acknowledge of the column step |
| send_req | input | 1 | Request to emit the current address |
| send_ack | output | 1 | Acknowledge of the send, given after the address is taken |
| addr_valid | output | 1 | Address on `addr_data` is valid |
| addr_ready | input | 1 | Receiver accepts the address |
| addr_data | output | 2*CNT_W | Address {column, row} |

## Verification
The bench builds the block with `CNT_W` = 3, so each ring holds eight positions. At that size a row or column count wraps after a handful of steps, which brings the R4 boundary well within a short run. Counts are observed only through send transactions at the output channel. The receiver stall is swept from zero to several cycles to exercise the hold rule of R6.

// File: rtl/addr_cnt_pkg.sv
package addr_cnt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_HOLD,
    ST_COL_HOLD,
    ST_SEND_WAIT,
    ST_SEND_HOLD
  } cnt_state_t;

  typedef enum logic [1:0] {
    GR_NONE,
    GR_ROW,
    GR_COL,
    GR_SEND
  } grant_t;
endpackage

// File: rtl/addr_cnt_inc.sv
module addr_cnt_inc #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] val_in,
  output logic [CNT_W-1:0] val_out
);
  logic [CNT_W:0] carry;

  assign carry[0] = 1'b1;

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    assign val_out[b]   = val_in[b] ^ carry[b];
    assign carry[b+1]   = val_in[b] & carry[b];
  end

  logic unused_carry;
  assign unused_carry = carry[CNT_W];
endmodule

// File: rtl/addr_cnt_pick.sv
module addr_cnt_pick
  import addr_cnt_pkg::*;
(
  input  logic   row_req,
  input  logic   col_req,
  input  logic   snd_req,
  output grant_t grant
);
  always_comb begin
    if (row_req)      grant = GR_ROW;
    else if (col_req) grant = GR_COL;
    else if (snd_req) grant = GR_SEND;
    else              grant = GR_NONE;
  end
endmodule

// File: rtl/addr_token_counter.sv
module addr_token_counter
  import addr_cnt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc_row_req,
  output logic               inc_row_ack,
  input  logic               inc_col_req,
  output logic               inc_col_ack,
  input  logic               send_req,
  output logic               send_ack,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [2*CNT_W-1:0] addr_data
);
  localparam int ADDR_W = 2 * CNT_W;

  cnt_state_t       state_q;
  grant_t           grant;
  logic [CNT_W-1:0] row_q;
  logic [CNT_W-1:0] col_q;
  logic [CNT_W-1:0] inc_in;
  logic [CNT_W-1:0] inc_out;

  addr_cnt_pick i_pick (
    .row_req (inc_row_req),
    .col_req (inc_col_req),
    .snd_req (send_req),
    .grant   (grant)
  );

  assign inc_in = (grant == GR_COL) ? col_q : row_q;

  addr_cnt_inc #(.CNT_W(CNT_W)) i_inc (
    .val_in  (inc_in),
    .val_out (inc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      row_q       <= '0;
      col_q       <= '0;
      inc_row_ack <= 1'b0;
      inc_col_ack <= 1'b0;
      send_ack    <= 1'b0;
      addr_valid  <= 1'b0;
      addr_data   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          case (grant)
            GR_ROW: begin
              row_q       <= inc_out;
              inc_row_ack <= 1'b1;
              state_q     <= ST_ROW_HOLD;
            end
            GR_COL: begin
              col_q       <= inc_out;
              inc_col_ack <= 1'b1;
              state_q     <= ST_COL_HOLD;
            end
            GR_SEND: begin
              addr_data  <= ADDR_W'({col_q, row_q});
              addr_valid <= 1'b1;
              state_q    <= ST_SEND_WAIT;
            end
            default: ;
          endcase
        end
        ST_ROW_HOLD: begin
          if (!inc_row_req) begin
            inc_row_ack <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        ST_COL_HOLD: begin
          if (!inc_col_req) begin
            inc_col_ack <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        ST_SEND_WAIT: begin
          if (addr_ready) begin
            addr_valid <= 1'b0;
            send_ack   <= 1'b1;
            state_q    <= ST_SEND_HOLD;
          end
        end
        ST_SEND_HOLD: begin
          if (!send_req) begin
            send_ack <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_token_counter_chk.sv
module addr_token_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               inc_row_req,
  input logic               inc_row_ack,
  input logic               inc_col_req,
  input logic               inc_col_ack,
  input logic               send_req,
  input logic               send_ack,
  input logic               addr_valid,
  input logic               addr_ready,
  input logic [2*CNT_W-1:0] addr_data,
  input logic [CNT_W-1:0]   row_cnt,
  input logic [CNT_W-1:0]   col_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inc_row_ack) |-> (row_cnt == $past(row_cnt) + ONE) && $stable(col_cnt));

  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inc_col_ack) |-> (col_cnt == $past(col_cnt) + ONE) && $stable(row_cnt));

  // R5
  addr_content_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_valid) |-> addr_data == {col_cnt, row_cnt});

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !addr_ready) |=> addr_valid && $stable(addr_data) && !send_ack);

  // R6
  ack_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(send_ack) |-> $past(addr_valid && addr_ready));

  // R7
  send_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_valid || send_ack) |=> $stable(row_cnt) && $stable(col_cnt));

  // R8
  row_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    inc_row_ack |-> $past(inc_row_req));

  // R8
  col_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    inc_col_ack |-> $past(inc_col_req));

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc_row_req, inc_col_req, send_req}));
endmodule

bind addr_token_counter addr_token_counter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .inc_row_req (inc_row_req),
  .inc_row_ack (inc_row_ack),
  .inc_col_req (inc_col_req),
  .inc_col_ack (inc_col_ack),
  .send_req    (send_req),
  .send_ack    (send_ack),
  .addr_valid  (addr_valid),
  .addr_ready  (addr_ready),
  .addr_data   (addr_data),
  .row_cnt     (row_q),
  .col_cnt     (col_q)
);

// File: tb/test_addr_token_counter.sv
module test_addr_token_counter;
  localparam int CNT_W  = 3;
  localparam int ADDR_W = 2 * CNT_W;
  localparam int NPOS   = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc_row_req = 1'b0, inc_col_req = 1'b0, send_req = 1'b0, addr_ready = 1'b0;
  logic inc_row_ack, inc_col_ack, send_ack, addr_valid;
  logic [ADDR_W-1:0] addr_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;
  int m_row    = 0;
  int m_col    = 0;

  always #2.5 clk = ~clk;

  addr_token_counter #(.CNT_W(CNT_W)) i_addr_token_counter (
    .clk (clk), .rst (rst),
    .inc_row_req (inc_row_req), .inc_row_ack (inc_row_ack),
    .inc_col_req (inc_col_req), .inc_col_ack (inc_col_ack),
    .send_req (send_req), .send_ack (send_ack),
    .addr_valid (addr_valid), .addr_ready (addr_ready),
    .addr_data (addr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr();
    return ((m_col % NPOS) << CNT_W) | (m_row % NPOS);
  endfunction

  task automatic bump_row();
    @(negedge clk) inc_row_req = 1'b1;
    @(negedge clk) chk(inc_row_ack == 1'b1, "R2 row ack high", int'(inc_row_ack), 1);
    chk(inc_col_ack == 1'b0, "R2 col ack untouched", int'(inc_col_ack), 0);
    inc_row_req = 1'b0;
    @(negedge clk) chk(inc_row_ack == 1'b0, "R2 row ack drop", int'(inc_row_ack), 0);
    m_row++;
  endtask

  task automatic bump_col();
    @(negedge clk) inc_col_req = 1'b1;
    @(negedge clk) chk(inc_col_ack == 1'b1, "R3 col ack high", int'(inc_col_ack), 1);
    chk(inc_row_ack == 1'b0, "R3 row ack untouched", int'(inc_row_ack), 0);
    inc_col_req = 1'b0;
    @(negedge clk) chk(inc_col_ack == 1'b0, "R3 col ack drop", int'(inc_col_ack), 0);
    m_col++;
  endtask

  task automatic do_send(input int stall, input string req);
    logic [ADDR_W-1:0] first;
    @(negedge clk) send_req = 1'b1;
    @(negedge clk);
    chk(addr_valid == 1'b1, "R5 valid raised", int'(addr_valid), 1);
    chk(int'(addr_data) == exp_addr(), req, int'(addr_data), exp_addr());
    first = addr_data;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(addr_valid == 1'b1 && addr_data == first, "R6 hold under stall",
          int'(addr_data), int'(first));
      chk(send_ack == 1'b0, "R6 no early ack", int'(send_ack), 0);
    end
    addr_ready = 1'b1;
    @(negedge clk);
    chk(addr_valid == 1'b0, "R6 valid drop on accept", int'(addr_valid), 0);
    chk(send_ack == 1'b1, "R6 ack after accept", int'(send_ack), 1);
    addr_ready = 1'b0;
    send_req   = 1'b0;
    @(negedge clk) chk(send_ack == 1'b0, "R6 ack release", int'(send_ack), 0);
  endtask

  task automatic t_reset();
    chk(!inc_row_ack && !inc_col_ack && !send_ack && !addr_valid, "R1 outputs idle",
        int'({inc_row_ack, inc_col_ack, send_ack, addr_valid}), 0);
    do_send(0, "R1 counts zero after reset");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!inc_row_ack && !inc_col_ack && !send_ack && !addr_valid, "R8 quiet when idle",
          int'({inc_row_ack, inc_col_ack, send_ack, addr_valid}), 0);
    end
  endtask

  task automatic t_steps();
    for (int k = 0; k < 3; k++) bump_row();
    do_send(1, "R2 row count stepped");
    for (int k = 0; k < 5; k++) bump_col();
    do_send(2, "R3 column count stepped");
  endtask

  task automatic t_wrap();
    while ((m_row % NPOS) != NPOS - 1) bump_row();
    do_send(0, "R4 row at top");
    bump_row();
    do_send(0, "R4 row wrapped to zero");
    while ((m_col % NPOS) != NPOS - 1) bump_col();
    bump_col();
    do_send(3, "R4 column wrapped to zero");
  endtask

  task automatic t_repeat_send();
    bump_col();
    bump_row();
    bump_row();
    do_send(4, "R7 first send");
    do_send(0, "R7 repeat send same address");
    do_send(1, "R7 third send same address");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_steps();
    t_wrap();
    t_repeat_send();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule